// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the SCL waveform of an I2C master. It runs on a fixed reference clock (24 MHz in the intended system) and alternates between a low phase, where it drives SCL low, and a high phase, where it releases SCL. Each phase length comes from its own 16-bit count. Each count is paired with a 16-bit offset that places a one-cycle strobe inside that phase. In the low phase this strobe tells the data path when it may change SDA (the transmit-drive strobe). In the high phase it tells the data path when to capture SDA (the receive-sample strobe). The two counts and their offsets are packed into two 32-bit configuration words.

A command engine sits beside this block and handles START/STOP conditions and byte sequencing. It pulses `start` to begin clocking and pulses `stop` to end clocking after the current low phase. It holds `retain` to park SCL low once a low phase ends. During the high phase the counter only advances while SCL actually reads high, so a slave stretching the clock lengthens the phase and delays the sample strobe. Typical programming for a target bus rate f uses base = (24e6/f − 38)/2, high count = base + 3, low count = base − 3, sample offset ≈ 3/4 of the high count and drive offset ≈ 1/4 of the low count. The configuration words must stay stable while the block is busy.

Top module: `i2c_scl_timer`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `scl_oe`=0 (SCL released), `busy`=0, and neither strobe is asserted.
- R2: A `start` pulse while idle makes `busy`=1 and `scl_oe`=1 from the next clock cycle, beginning a low phase at count 0.
- R3: A low phase keeps `scl_oe`=1 for max(L,1) cycles, where L is `cfg_low[31:16]`.
- R4: During a low phase `tx_drive` is a single-cycle pulse at cycle index D of the phase (index 0 is the first cycle), where D is `cfg_low[15:0]`. There is no pulse when D ≥ max(L,1).
- R5: A high phase keeps `scl_oe`=0 for max(H,1) cycles in which `scl_in` reads high, where H is `cfg_high[31:16]`. Unless stopped or parked, high and low phases alternate.
- R6: During a high phase `rx_sample` is a single-cycle pulse on the counted cycle with index P, where P is `cfg_high[15:0]`. There is no pulse when P ≥ max(H,1). `rx_sample` is only asserted while `scl_in` is high.
- R7: In a high phase, each cycle in which `scl_in` reads low does not advance the count and carries no `rx_sample`. Holding SCL low for S cycles therefore lengthens the phase by S and delays the sample by S.
- R8: A `stop` pulse during a low or high phase is remembered. The low phase then in progress, or the next one if the block is in a high phase, runs its full length. The block then goes idle (`busy`=0, `scl_oe`=0). A `stop` pulse while idle is ignored.
- R9: If `retain` is high when a low phase ends, SCL stays driven low indefinitely (`busy`=1) with no strobes, until a `start` begins a fresh low phase or a `stop` returns the block to idle on the next cycle.
- R10: A `start` pulse while a low or high phase is running is ignored; the phase timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_high | input | 32 | High-phase count in [31:16], receive-sample offset in [15:0] |
| cfg_low | input | 32 | Low-phase count in [31:16], transmit-drive offset in [15:0] |
| start | input | 1 | Begin clocking from idle or from the parked state |
| stop | input | 1 | End clocking after the current or next low phase |
| retain | input | 1 | Park SCL low at the end of a low phase |
| scl_in | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | 1 drives SCL low, 0 releases it |
| busy | output | 1 | Clock generation active or parked |
| tx_drive | output | 1 | One-cycle strobe: SDA may change now |
| rx_sample | output | 1 | One-cycle strobe: capture SDA now |

## Verification
A wrong phase state or count shows at the ports within one phase. `scl_oe` stays asserted for the wrong number of cycles, or a strobe lands on the wrong cycle index, is missing, or appears twice, and the next phase boundary exposes it. A stop flag that is lost or left set shows after the following low phase: the block either keeps clocking or falls idle too early. A count that advances while SCL is held low shows as a sample strobe too early and a high phase too short by exactly the stretch length.

// File: rtl/i2c_scl_pkg.sv
// Shared types and helpers for the SCL timing generator.
// Assumes configuration words of REG_W bits carry a count in the upper
// CNT_W bits and an offset in the lower CNT_W bits.
package i2c_scl_pkg;

    // Phase of the SCL waveform generator
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_PARK = 2'd3
    } scl_phase_t;

endpackage

// File: rtl/i2c_scl_field_split.sv
// Splits one configuration word into the index of the last cycle of a
// phase and the strobe offset. A zero count is treated as one cycle.
// Assumes REG_W >= 2*CNT_W.
module i2c_scl_field_split #(
    parameter int REG_W = 32,
    parameter int CNT_W = 16
) (
    input  logic [REG_W-1:0] cfg_word,
    output logic [CNT_W-1:0] last_idx,
    output logic [CNT_W-1:0] strobe_off
);

    localparam int LEN_LSB = REG_W - CNT_W;

    logic [CNT_W-1:0] len_field;

    // Extract fields and derive the last counted index of the phase
    always_comb begin
        len_field  = cfg_word[LEN_LSB +: CNT_W];
        strobe_off = cfg_word[CNT_W-1:0];
        if (len_field == '0) begin
            last_idx = '0;
        end else begin
            last_idx = len_field - 1'b1;
        end
    end

endmodule

// File: rtl/i2c_scl_phase_ctr.sv
// Position counter shared by the high and low phases. It clears on
// request, advances on request, and compares against the selected
// phase's last index and strobe offset.
module i2c_scl_phase_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] last_idx,
    input  logic [CNT_W-1:0] strobe_off,
    output logic             at_last,
    output logic             at_off
);

    logic [CNT_W-1:0] pos_q;

    // Hold the position within the current phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (clr) begin
            pos_q <= '0;
        end else if (adv) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // Compare the position against the phase limits
    always_comb begin
        at_last = (pos_q == last_idx);
        at_off  = (pos_q == strobe_off);
    end

endmodule

// File: rtl/i2c_scl_seq.sv
// Phase sequencer: walks idle -> low -> high -> low ... and handles
// stop (deferred to the end of a low phase), retain (park low) and
// clock stretching (no advance while SCL reads low in the high phase).
module i2c_scl_seq
    import i2c_scl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic       retain,
    input  logic       scl_in,
    input  logic       at_last,
    output scl_phase_t phase,
    output logic       ctr_clr,
    output logic       ctr_adv
);

    scl_phase_t phase_q, phase_d;
    logic       stop_pend_q, stop_pend_d;
    logic       stop_now;

    // Next phase and counter control
    always_comb begin
        phase_d  = phase_q;
        ctr_clr  = 1'b0;
        ctr_adv  = 1'b0;
        stop_now = stop | stop_pend_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d = PH_LOW;
                    ctr_clr = 1'b1;
                end
            end
            PH_LOW: begin
                if (at_last) begin
                    ctr_clr = 1'b1;
                    if (stop_now) begin
                        phase_d = PH_IDLE;
                    end else if (retain) begin
                        phase_d = PH_PARK;
                    end else begin
                        phase_d = PH_HIGH;
                    end
                end else begin
                    ctr_adv = 1'b1;
                end
            end
            PH_HIGH: begin
                if (scl_in) begin
                    if (at_last) begin
                        phase_d = PH_LOW;
                        ctr_clr = 1'b1;
                    end else begin
                        ctr_adv = 1'b1;
                    end
                end
            end
            PH_PARK: begin
                ctr_clr = 1'b1;
                if (stop) begin
                    phase_d = PH_IDLE;
                end else if (start) begin
                    phase_d = PH_LOW;
                end
            end
            default: begin
                phase_d = PH_IDLE;
            end
        endcase
    end

    // Remember a stop request until the block returns to idle
    always_comb begin
        if (phase_d == PH_IDLE) begin
            stop_pend_d = 1'b0;
        end else if (stop && (phase_q == PH_LOW || phase_q == PH_HIGH)) begin
            stop_pend_d = 1'b1;
        end else begin
            stop_pend_d = stop_pend_q;
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            stop_pend_q <= 1'b0;
        end else begin
            phase_q     <= phase_d;
            stop_pend_q <= stop_pend_d;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/i2c_scl_timer.sv
// SCL timing generator top. Decodes the two configuration words, selects
// the limits of the active phase for the shared counter, and forms the
// SCL drive enable and the two strobes. Configuration must stay stable
// while busy. Strobes are combinational from registered state (rx_sample
// additionally gated by scl_in).
module i2c_scl_timer
    import i2c_scl_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] cfg_high,
    input  logic [REG_W-1:0] cfg_low,
    input  logic             start,
    input  logic             stop,
    input  logic             retain,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             busy,
    output logic             tx_drive,
    output logic             rx_sample
);

    localparam int N_WORDS = 2;
    localparam int IDX_LOW  = 0;
    localparam int IDX_HIGH = 1;

    logic [REG_W-1:0] cfg_words [N_WORDS];
    logic [CNT_W-1:0] last_arr  [N_WORDS];
    logic [CNT_W-1:0] off_arr   [N_WORDS];
    logic [CNT_W-1:0] sel_last, sel_off;
    logic             at_last, at_off, ctr_clr, ctr_adv;
    scl_phase_t       phase;

    assign cfg_words[IDX_LOW]  = cfg_low;
    assign cfg_words[IDX_HIGH] = cfg_high;

    // One field decoder per configuration word
    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_split
        i2c_scl_field_split #(
            .REG_W(REG_W),
            .CNT_W(CNT_W)
        ) u_split (
            .cfg_word  (cfg_words[gi]),
            .last_idx  (last_arr[gi]),
            .strobe_off(off_arr[gi])
        );
    end

    // Pick the limits of the phase in progress
    always_comb begin
        if (phase == PH_HIGH) begin
            sel_last = last_arr[IDX_HIGH];
            sel_off  = off_arr[IDX_HIGH];
        end else begin
            sel_last = last_arr[IDX_LOW];
            sel_off  = off_arr[IDX_LOW];
        end
    end

    i2c_scl_phase_ctr #(
        .CNT_W(CNT_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ctr_clr),
        .adv       (ctr_adv),
        .last_idx  (sel_last),
        .strobe_off(sel_off),
        .at_last   (at_last),
        .at_off    (at_off)
    );

    i2c_scl_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .stop   (stop),
        .retain (retain),
        .scl_in (scl_in),
        .at_last(at_last),
        .phase  (phase),
        .ctr_clr(ctr_clr),
        .ctr_adv(ctr_adv)
    );

    // Form the line drive and the strobes from the phase
    always_comb begin
        scl_oe    = (phase == PH_LOW) || (phase == PH_PARK);
        busy      = (phase != PH_IDLE);
        tx_drive  = (phase == PH_LOW) && at_off;
        rx_sample = (phase == PH_HIGH) && scl_in && at_off;
    end

endmodule

// File: rtl/i2c_scl_timer_chk.sv
// Port-level property checker for the SCL timing generator, bound to
// every instance of the top module.
module i2c_scl_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic scl_in,
    input logic scl_oe,
    input logic busy,
    input logic tx_drive,
    input logic rx_sample
);

    // R1: idle means released line and no strobes
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !tx_drive && !rx_sample));

    // R2: start from idle enters a driven-low phase next cycle
    a_r2_start_enters_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && scl_oe));

    // R8: without start, idle persists (stop while idle has no effect)
    a_r8_idle_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    // R4: drive strobe only while SCL is driven low, one cycle wide
    a_r4_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drive |-> scl_oe);
    a_r4_drive_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drive |=> !tx_drive);

    // R6: sample strobe only with SCL released and reading high, one cycle wide
    a_r6_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sample |-> (!scl_oe && scl_in));
    a_r6_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sample |=> !rx_sample);

    // R7: no sample while a slave holds SCL low
    a_r7_no_sample_stretched: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !scl_oe && !scl_in) |-> !rx_sample);

    // R4/R6: the two strobes never coincide
    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_drive && rx_sample));

endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .scl_in   (scl_in),
    .scl_oe   (scl_oe),
    .busy     (busy),
    .tx_drive (tx_drive),
    .rx_sample(rx_sample)
);

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_high = '0;
    logic [31:0] cfg_low = '0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        retain_i = 1'b0;
    logic        hold_low = 1'b0;
    logic        scl_in;
    logic        scl_oe, busy, tx_drive, rx_sample;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Open-drain line: low if the master drives or the slave holds it
    assign scl_in = ~scl_oe & ~hold_low;

    i2c_scl_timer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_high (cfg_high),
        .cfg_low  (cfg_low),
        .start    (start_i),
        .stop     (stop_i),
        .retain   (retain_i),
        .scl_in   (scl_in),
        .scl_oe   (scl_oe),
        .busy     (busy),
        .tx_drive (tx_drive),
        .rx_sample(rx_sample)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_len(input int len);
        return (len == 0) ? 1 : len;
    endfunction

    function automatic int exp_pos(input int off, input int len);
        return (off < eff_len(len)) ? off : -1;
    endfunction

    function automatic int exp_cnt(input int off, input int len);
        return (off < eff_len(len)) ? 1 : 0;
    endfunction

    task automatic start_pulse();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Measure a driven-low stretch from its first cycle
    task automatic measure_low(input int limit, input int poke_start, input int poke_stop,
                               output int len, output int pos, output int np);
        len = 0; pos = -1; np = 0;
        while (scl_oe && len < limit) begin
            start_i = (len == poke_start);
            stop_i  = (len == poke_stop);
            if (tx_drive) begin
                if (pos < 0) pos = len;
                np++;
            end
            len++;
            @(negedge clk);
        end
        start_i = 1'b0;
        stop_i  = 1'b0;
    endtask

    // Measure a released stretch, the slave holding SCL low for the first s cycles
    task automatic measure_high(input int s, input int limit, input int poke_stop,
                                output int len, output int pos, output int np);
        len = 0; pos = -1; np = 0;
        forever begin
            hold_low = (len < s);
            stop_i   = (len == poke_stop);
            #1;
            if (scl_oe || len >= limit) break;
            if (rx_sample) begin
                if (pos < 0) pos = len;
                np++;
            end
            len++;
            @(negedge clk);
        end
        hold_low = 1'b0;
        stop_i   = 1'b0;
    endtask

    // Full low/high/low run ending with a stop, checked against the requirements
    task automatic run_pair(input int lo, input int dp, input int hi, input int sp, input int s);
        int l, p, n, ep;
        string rq;
        cfg_low  = {16'(lo), 16'(dp)};
        cfg_high = {16'(hi), 16'(sp)};
        start_pulse();
        chk("R2", "busy after start", int'(busy), 1);
        measure_low(2000, -1, -1, l, p, n);
        chk("R3", "low length", l, eff_len(lo));
        chk("R4", "drive index", p, exp_pos(dp, lo));
        chk("R4", "drive count", n, exp_cnt(dp, lo));
        measure_high(s, 2000, 0, l, p, n);
        rq = (s > 0) ? "R7" : "R5";
        chk(rq, "high length", l, s + eff_len(hi));
        ep = exp_pos(sp, hi);
        chk((s > 0) ? "R7" : "R6", "sample index", p, (ep < 0) ? -1 : ep + s);
        chk("R6", "sample count", n, exp_cnt(sp, hi));
        measure_low(2000, -1, -1, l, p, n);
        chk("R8", "final low length", l, eff_len(lo));
        chk("R8", "busy after stop", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk("R8", "still idle", int'(busy) + int'(scl_oe), 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run incomplete actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int l, p, n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", "oe in reset", int'(scl_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "strobes after reset", int'(tx_drive) + int'(rx_sample), 0);
        chk("R1", "oe after reset", int'(scl_oe), 0);

        // Directed runs: typical, zero counts, offsets past the end, stretching
        run_pair(5, 1, 7, 5, 0);
        run_pair(0, 0, 0, 0, 0);
        run_pair(4, 9, 3, 3, 0);
        run_pair(6, 5, 8, 0, 3);
        run_pair(9, 2, 12, 11, 5);

        // R8: stop while idle is ignored, next run must still reach a high phase
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "stop while idle keeps idle", int'(busy), 0);
        run_pair(3, 0, 4, 2, 0);

        // R10: start during a low phase does not restart it
        cfg_low  = {16'd8, 16'd6};
        cfg_high = {16'd5, 16'd2};
        start_pulse();
        measure_low(2000, 2, -1, l, p, n);
        chk("R10", "low length with start poke", l, 8);
        chk("R10", "drive index with start poke", p, 6);
        measure_high(0, 2000, 1, l, p, n);
        chk("R10", "high length", l, 5);
        measure_low(2000, -1, -1, l, p, n);
        chk("R8", "idle after stop in high", int'(busy), 0);

        // R9: park low with retain, resume with start
        cfg_low  = {16'd6, 16'd2};
        cfg_high = {16'd4, 16'd1};
        retain_i = 1'b1;
        start_pulse();
        measure_low(40, -1, -1, l, p, n);
        chk("R9", "parked low stays driven", l, 40);
        chk("R9", "single drive strobe before park", n, 1);
        retain_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9", "park holds without retain", int'(scl_oe) + int'(busy), 2);
        start_pulse();
        measure_low(2000, -1, -1, l, p, n);
        chk("R9", "fresh low after park", l, 6);
        chk("R9", "drive index after park", p, 2);
        measure_high(0, 2000, 0, l, p, n);
        chk("R9", "high after park", l, 4);
        measure_low(2000, -1, -1, l, p, n);
        chk("R8", "idle after resumed run", int'(busy), 0);

        // R9: stop while parked releases the line next cycle
        retain_i = 1'b1;
        start_pulse();
        measure_low(20, -1, -1, l, p, n);
        retain_i = 1'b0;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R9", "stop from park", int'(busy) + int'(scl_oe), 0);

        // Random configurations with random stretching
        for (int it = 0; it < 12; it++) begin
            int lo, dp, hi, sp, s;
            lo = $urandom_range(0, 30);
            hi = $urandom_range(0, 30);
            dp = $urandom_range(0, lo + 2);
            sp = $urandom_range(0, hi + 2);
            s  = $urandom_range(0, 4);
            run_pair(lo, dp, hi, sp, s);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule